// File: doc/BRIEF.md
# SPAD quench and hold-off sequencer

This block is the digital controller behind one single-photon detector pixel. A thresholded detection level comes in from the pixel comparator. When the level rises, the block drives the quench switch and sends a one-cycle event pulse to the pixel's timing logic. It keeps the diode quenched for a programmable number of clock cycles. It then releases quench, waits through a dead cycle in which neither switch is driven, and drives the recharge switch for a fixed short time before it accepts the next detection.

Hold-off is given in clock cycles. With a 5 ns clock, the 8-bit setting covers 10 ns (a value of 2) up to 800 ns (a value of 160) and beyond. Long settings give trapped carriers time to leave before the diode is re-armed, which lowers afterpulsing at the cost of peak count rate. A global arm level, shared by the whole array, gates detection. So does a per-pixel disable bit that the configuration logic holds.

The block expects the comparator level to be synchronous to the clock. The analog switches are modelled as the two drive outputs.

Top module: `spad_qh_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, quench_o, recharge_o and event_o are all 0.
- R2: A 0-to-1 change of det_i, sampled at a clock edge while the sequencer is idle, arm_i is 1 and pix_off_i is 0, sets quench_o to 1 after that edge. At the same edge event_o goes to 1 for exactly one cycle.
- R3: quench_o stays 1 for H cycles, where H is holdoff_i sampled at the triggering edge, or 2 if that value is 0 or 1 (8-bit setting, so H ranges from 2 to 255). A change of holdoff_i after the trigger does not alter the running hold-off.
- R4: After quench_o falls there is exactly 1 cycle with both drives at 0, then recharge_o is 1 for exactly 2 cycles, and then the sequencer is idle.
- R5: quench_o and recharge_o are never 1 in the same cycle.
- R6: With pix_off_i at 1, a rising det_i produces no event and no quench.
- R7: With arm_i at 0, a rising det_i produces no event and no quench.
- R8: A rising det_i sampled while quench, the dead cycle or recharge is in progress produces no event and does not change the length of any phase.
- R9: Only a 0-to-1 change triggers. A det_i level that rose while the pixel was gated and then stays high does not trigger once the gate opens. Dropping arm_i or setting pix_off_i during a sequence does not cut the sequence short.
- R10: A rising det_i sampled in the first idle cycle after recharge ends is accepted as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| det_i | input | 1 | Comparator output, high while the pixel node is above threshold |
| arm_i | input | 1 | Array-wide arm level; 0 blocks new detections |
| pix_off_i | input | 1 | Per-pixel disable bit; 1 blocks new detections |
| holdoff_i | input | 8 | Hold-off length in clock cycles (values below 2 act as 2) |
| quench_o | output | 1 | Quench switch drive |
| recharge_o | output | 1 | Recharge switch drive |
| event_o | output | 1 | One-cycle detection pulse to the timing logic |

## Verification
Single detections are tried at hold-off settings of 0, 1, 2, 37, 160 and 255. These separate the clamp from the pass-through of the setting and show the counter boundaries at both ends. Second rises are placed at every cycle offset through quench, the dead cycle and recharge, and then in the first idle cycle. This pins down the exact cycle in which the pixel becomes ready again. Gated stimuli use pix_off_i and arm_i separately, plus a level held high across gate opening. The hold-off setting is also changed during quench and the gate is dropped during a sequence. Together these show that only the captured rising edge and the captured setting drive a sequence.

// File: rtl/spad_qh_pkg.sv
package spad_qh_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_QUENCH = 2'd1,
    SEQ_DEAD   = 2'd2,
    SEQ_RECH   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/spad_qh_rst_sync.sv
module spad_qh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/spad_qh_edge.sv
module spad_qh_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  // Held at 1 in reset so a level already high at release does not count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
    end else begin
      level_q <= level_i;
    end
  end

  assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/spad_qh_timer.sv
module spad_qh_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spad_qh_seq.sv
module spad_qh_seq #(
  parameter int HOLD_W   = 8,
  parameter int MIN_HOLD = 2,
  parameter int GAP_CYC  = 1,
  parameter int RECH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_i,
  input  logic              arm_i,
  input  logic              pix_off_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              quench_o,
  output logic              recharge_o,
  output logic              event_o
);

  import spad_qh_pkg::*;

  localparam logic [HOLD_W-1:0] MIN_HOLD_V = HOLD_W'(MIN_HOLD);
  localparam logic [HOLD_W-1:0] GAP_LOAD   = HOLD_W'(GAP_CYC - 1);
  localparam logic [HOLD_W-1:0] RECH_LOAD  = HOLD_W'(RECH_CYC - 1);

  logic              rst_sync_n;
  logic              det_rise;
  logic              accept;
  logic              tmr_zero;
  logic              tmr_load;
  logic [HOLD_W-1:0] tmr_val;
  logic [HOLD_W-1:0] hold_eff;
  seq_state_t        state_q;
  seq_state_t        state_d;
  logic              event_d;

  spad_qh_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  spad_qh_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (det_i),
    .rise_o  (det_rise)
  );

  spad_qh_timer #(.W(HOLD_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign hold_eff = (holdoff_i < MIN_HOLD_V) ? MIN_HOLD_V : holdoff_i;
  assign accept   = det_rise & arm_i & ~pix_off_i;

  // Next-state logic: one shared down-counter times every phase.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    event_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_d  = SEQ_QUENCH;
          tmr_load = 1'b1;
          tmr_val  = hold_eff - HOLD_W'(1);
          event_d  = 1'b1;
        end
      end
      SEQ_QUENCH: begin
        if (tmr_zero) begin
          state_d  = SEQ_DEAD;
          tmr_load = 1'b1;
          tmr_val  = GAP_LOAD;
        end
      end
      SEQ_DEAD: begin
        if (tmr_zero) begin
          state_d  = SEQ_RECH;
          tmr_load = 1'b1;
          tmr_val  = RECH_LOAD;
        end
      end
      SEQ_RECH: begin
        if (tmr_zero) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // State and drive registers; drives come straight from flops.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= SEQ_IDLE;
      quench_o   <= 1'b0;
      recharge_o <= 1'b0;
      event_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      quench_o   <= (state_d == SEQ_QUENCH);
      recharge_o <= (state_d == SEQ_RECH);
      event_o    <= event_d;
    end
  end

endmodule

// File: rtl/spad_qh_seq_chk.sv
module spad_qh_seq_chk #(
  parameter int HOLD_W   = 8,
  parameter int MIN_HOLD = 2,
  parameter int GAP_CYC  = 1,
  parameter int RECH_CYC = 2
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              arm_i,
  input logic              pix_off_i,
  input logic [HOLD_W-1:0] holdoff_i,
  input logic              quench_o,
  input logic              recharge_o,
  input logic              event_o
);

  localparam int LEN_W = HOLD_W + 1;

  logic [HOLD_W-1:0] cfg_d;
  logic [LEN_W-1:0]  hexp;
  logic [LEN_W-1:0]  qlen;
  logic [LEN_W-1:0]  rlen;
  logic [LEN_W-1:0]  gcnt;

  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] x);
    return (x == '1) ? x : x + LEN_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_d <= '0;
      hexp  <= '0;
      qlen  <= '0;
      rlen  <= '0;
      gcnt  <= '0;
    end else begin
      cfg_d <= holdoff_i;
      if (event_o) begin
        hexp <= (int'(cfg_d) < MIN_HOLD) ? LEN_W'(MIN_HOLD) : LEN_W'(cfg_d);
      end
      qlen <= quench_o   ? sat_inc(qlen) : '0;
      rlen <= recharge_o ? sat_inc(rlen) : '0;
      gcnt <= (quench_o || recharge_o) ? '0 : sat_inc(gcnt);
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_ns) begin
      a_r1_reset_idle: assert (!quench_o && !recharge_o && !event_o)
        else $error("R1 drives active in reset");
    end
  end

  a_r2_event_single: assert property (@(posedge clk) disable iff (!rst_ns)
    event_o |=> !event_o);

  a_r2_event_with_quench: assert property (@(posedge clk) disable iff (!rst_ns)
    event_o |-> $rose(quench_o));

  a_r3_hold_len: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(quench_o) |-> (qlen == hexp));

  a_r4_dead_cycle: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(quench_o) |-> !recharge_o);

  a_r4_gap_len: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(recharge_o) |-> (gcnt == LEN_W'(GAP_CYC)));

  a_r4_recharge_len: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(recharge_o) |-> (rlen == LEN_W'(RECH_CYC)));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_ns)
    !(quench_o && recharge_o));

  // R6 and R7: a sequence only starts if the gates were open at the trigger.
  a_r6_gated_start: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(quench_o) |-> $past(arm_i && !pix_off_i));

  a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_ns)
    event_o |-> $past(!quench_o && !recharge_o));

endmodule

bind spad_qh_seq spad_qh_seq_chk #(
  .HOLD_W   (HOLD_W),
  .MIN_HOLD (MIN_HOLD),
  .GAP_CYC  (GAP_CYC),
  .RECH_CYC (RECH_CYC)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_sync_n),
  .arm_i      (arm_i),
  .pix_off_i  (pix_off_i),
  .holdoff_i  (holdoff_i),
  .quench_o   (quench_o),
  .recharge_o (recharge_o),
  .event_o    (event_o)
);

// File: tb/spad_qh_seq_test.sv
module spad_qh_seq_test;

  logic       clk;
  logic       rst_n;
  logic       det;
  logic       arm;
  logic       pix_off;
  logic [7:0] hcfg;
  logic       quench_o;
  logic       recharge_o;
  logic       event_o;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int seen   = 0;
  int exp_q[$];

  spad_qh_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_i      (det),
    .arm_i      (arm),
    .pix_off_i  (pix_off),
    .holdoff_i  (hcfg),
    .quench_o   (quench_o),
    .recharge_o (recharge_o),
    .event_o    (event_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c < 2) ? 2 : c;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: raise det for one cycle; push the expected hold-off if accepted.
  task automatic fire(input int cfg, input bit accept, input string req);
    hcfg = 8'(cfg);
    det  = 1'b1;
    if (accept) begin
      exp_q.push_back(eff(cfg));
      pushed++;
    end
    @(negedge clk);
    det = 1'b0;
    if (accept) begin
      chk(quench_o && event_o, req, "quench/event after trigger edge",
          int'({quench_o, event_o}), 3);
    end
  endtask

  task automatic settle();
    tick(3);
    while (quench_o || recharge_o) tick(1);
    tick(3);
  endtask

  // Monitor: measures each sequence and compares it with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && event_o) begin
        int  exp_h;
        int  qn;
        int  rn;
        bit  extra;
        bit  ovl;
        seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 R7 R8", "unexpected event", 1, 0);
          exp_h = -1;
        end else begin
          exp_h = exp_q.pop_front();
        end
        qn = 0; rn = 0; extra = 0; ovl = 0;
        while (quench_o) begin
          qn++;
          if (qn > 1 && event_o) extra = 1;
          if (recharge_o) ovl = 1;
          @(negedge clk);
        end
        if (exp_h >= 0) chk(qn == exp_h, "R3", "quench length", qn, exp_h);
        chk(!recharge_o, "R4", "dead cycle recharge", int'(recharge_o), 0);
        if (event_o) extra = 1;
        @(negedge clk);
        while (recharge_o) begin
          rn++;
          if (event_o) extra = 1;
          if (quench_o) ovl = 1;
          @(negedge clk);
        end
        chk(rn == 2, "R4", "recharge length", rn, 2);
        chk(!extra, "R2 R8", "extra event inside sequence", int'(extra), 0);
        chk(!ovl, "R5", "quench and recharge overlap", int'(ovl), 0);
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "ALL", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; det = 1'b0; arm = 1'b1; pix_off = 1'b0; hcfg = 8'd2;
    tick(4);
    chk(!quench_o && !recharge_o && !event_o, "R1", "drives in reset",
        int'({quench_o, recharge_o, event_o}), 0);
    rst_n = 1'b1;
    tick(4);
    chk(!quench_o && !recharge_o && !event_o, "R1", "drives after release",
        int'({quench_o, recharge_o, event_o}), 0);

    // R2 R3: basic lengths, clamp and counter ends
    fire(2, 1, "R2"); settle();
    fire(0, 1, "R2"); settle();
    fire(1, 1, "R2"); settle();
    fire(37, 1, "R2"); settle();
    fire(160, 1, "R2"); settle();
    fire(255, 1, "R2"); settle();

    // R6: pixel disabled
    pix_off = 1'b1;
    fire(20, 0, "R6");
    tick(5);
    chk(!quench_o && !event_o, "R6", "disabled pixel responded",
        int'({quench_o, event_o}), 0);
    pix_off = 1'b0; tick(3);

    // R7: array disarmed
    arm = 1'b0;
    fire(20, 0, "R7");
    tick(5);
    chk(!quench_o && !event_o, "R7", "disarmed pixel responded",
        int'({quench_o, event_o}), 0);
    arm = 1'b1; tick(3);

    // R8: second rise at offsets 2..5 cycles falls in quench/dead/recharge (H=2)
    for (int k = 2; k <= 5; k++) begin
      fire(2, 1, "R8");
      tick(k - 1);
      fire(2, 0, "R8");
      settle();
    end
    // R8: rise during a long quench
    fire(10, 1, "R8"); tick(3); fire(10, 0, "R8"); settle();

    // R10: rise at offset 6 lands on the first idle cycle
    fire(2, 1, "R10");
    tick(5);
    fire(3, 1, "R10");
    settle();

    // R9: level raised while gated, held across gate opening
    pix_off = 1'b1;
    det = 1'b1;
    tick(3);
    pix_off = 1'b0;
    tick(5);
    chk(!quench_o && !event_o, "R9", "held level triggered",
        int'({quench_o, event_o}), 0);
    det = 1'b0; tick(2);
    fire(4, 1, "R9"); settle();

    // R3: setting changed during quench keeps the captured value
    fire(20, 1, "R3");
    hcfg = 8'd3;
    settle();

    // R9: gate dropped during a sequence does not cut it short
    fire(12, 1, "R9");
    arm = 1'b0; pix_off = 1'b1;
    settle();
    arm = 1'b1; pix_off = 1'b0; tick(3);

    chk(exp_q.size() == 0, "R2", "expected events left unseen", exp_q.size(), 0);
    chk(seen == pushed, "R8", "event count", seen, pushed);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule